// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block turns a simple request stream into the strobe sequence of a multiplexed-address EDO DRAM array. Each request carries a read/write flag, a row, a column and a 72-bit word made of 64 data bits and 8 check bits. The sequencer opens the row by dropping the row strobe with the row on the shared address pins, then drops the column strobe with the column on the same pins. Writes are performed as early writes, with W low before the column strobe falls. Read data is captured from the array and returned with a one-cycle done pulse.

Every analog timing minimum is a nanosecond parameter, rounded up to whole clock cycles against a clock-period parameter. When the next request targets the row that is already open, the sequencer stays in hyper page mode: the row strobe stays low and only the column strobe cycles. It closes the row when a request targets a different row, when no request is waiting, or when the maximum row-strobe low time would be exceeded. A parameter selects an array with 12 row bits and 12 column bits, or one with 13 row bits and 11 column bits.

Top module: `edo_seq`

## Requirements
- R1: While reset is applied and directly after it, ras_no_o, cas_no_o, we_no_o and oe_no_o are 1, dq_oe_o and rd_done_o are 0, and req_ready_o is 1.
- R2: The row of an accepted request is on addr_o when ras_no_o falls. Its column, zero-extended, is on addr_o when cas_no_o falls. Requests are served in order of acceptance.
- R3: ras_no_o stays low for at least T_RAS_NS and high for at least T_RP_NS. Two row-strobe falls are at least T_RC_NS apart. The row strobe falls at least T_RCD_NS before the column strobe.
- R4: In a read, we_no_o stays 1 and oe_no_o is 0 only while cas_no_o is 0. cas_no_o stays low for at least max(T_CAS_NS, T_CAC_NS), and its rise comes at least T_RAC_NS after the row strobe fell. rd_done_o is a single-cycle pulse in the first cycle with cas_no_o high again, and rd_data_o then holds the word the array drove.
- R5: In a write, we_no_o is 0 in the cycle before cas_no_o falls and through the whole column-strobe low time. dq_oe_o is 1 with the request word on dq_o when cas_no_o falls, and oe_no_o stays 1.
- R6: A request to the open row is accepted without raising ras_no_o. Column strobes inside one row are at least T_HPC_NS apart fall to fall, and the column strobe is high for at least T_CP_NS between them. cas_no_o is low only while ras_no_o is low.
- R7: A request to a row other than the open one is served only after ras_no_o has risen and fallen again with the new row.
- R8: ras_no_o never stays low for T_RASP_NS or longer. Page hits are refused once the row has been open long enough that another column access would not fit.
- R9: A request is taken only in a cycle with req_valid_i and req_ready_o both 1, and ras_no_o is low in the cycle after. With no request waiting, the open row is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request taken in this cycle if valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_row_i | input | ROW_W | Row address |
| req_col_i | input | COL_W | Column address |
| req_wdata_i | input | DW | Write word (data and check bits) |
| rd_data_o | output | DW | Last captured read word |
| rd_done_o | output | 1 | One-cycle pulse when rd_data_o is new |
| ras_no_o | output | 1 | Row strobe, active low |
| cas_no_o | output | 1 | Column strobe, active low |
| we_no_o | output | 1 | Write enable, active low |
| oe_no_o | output | 1 | Output enable, active low |
| addr_o | output | ROW_W | Shared row/column address |
| dq_o | output | DW | Data driven toward the array |
| dq_oe_o | output | 1 | Data bus drive enable |
| dq_i | input | DW | Data returned by the array |

## Verification
A behavioural DRAM model latches row and column on the strobe edges, checks every minimum in nanoseconds, and stores and returns words. Isolated single reads and writes show the full activate–access–precharge sequence and the R3/R4 minimums. Back-to-back requests to one row separate page hits from reopening the row. An alternating-row pair shows that a miss forces a full close. A long same-row burst with a short maximum row-low time shows that page hits are refused before the limit and the row is reopened. Corner addresses at all-zeros and all-ones check the address multiplexing.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_CSET, ST_COL, ST_CPRE, ST_RPRE
  } edo_state_e;

  function automatic int edo_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int edo_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/edo_dwell.sv
module edo_dwell #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (restart_i)      cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/edo_rowtrk.sv
module edo_rowtrk #(
  parameter int ROW_W   = 12,
  parameter int CW      = 8,
  parameter int N_RASL  = 3,
  parameter int N_RASP  = 100,
  parameter int N_GUARD = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             ras_low_i,
  input  logic [ROW_W-1:0] cmp_row_i,
  output logic [ROW_W-1:0] row_o,
  output logic             hit_o,
  output logic             rasl_ok_o,
  output logic             rasp_ok_o
);
  localparam logic [CW-1:0] L_RASL = CW'(N_RASL - 1);
  localparam logic [CW-1:0] L_PAGE = CW'(N_RASP - N_GUARD);

  logic [ROW_W-1:0] row_q;
  logic [CW-1:0]    low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (open_i) row_q <= row_i;
  end

  // cycles the row strobe has been low, 0 in its first low cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           low_q <= '0;
    else if (!ras_low_i)   low_q <= '0;
    else if (low_q != '1)  low_q <= low_q + 1'b1;
  end

  assign row_o     = row_q;
  assign hit_o     = ras_low_i && (row_q == cmp_row_i);
  assign rasl_ok_o = low_q >= L_RASL;
  assign rasp_ok_o = low_q < L_PAGE;

  // R8
  rasp_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_low_i |-> (int'(low_q) < N_RASP));
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int CLK_NS     = 20,
  parameter int REFRESH_8K = 0,
  parameter int DW         = 72,
  parameter int T_RAS_NS   = 60,
  parameter int T_RP_NS    = 40,
  parameter int T_RC_NS    = 104,
  parameter int T_RCD_NS   = 20,
  parameter int T_RAC_NS   = 60,
  parameter int T_CAC_NS   = 15,
  parameter int T_AA_NS    = 30,
  parameter int T_CAS_NS   = 10,
  parameter int T_CP_NS    = 10,
  parameter int T_HPC_NS   = 25,
  parameter int T_RASP_NS  = 200000,
  localparam int ROW_W     = 12 + REFRESH_8K,
  localparam int COL_W     = 12 - REFRESH_8K
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic [DW-1:0]    req_wdata_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_done_o,
  output logic             ras_no_o,
  output logic             cas_no_o,
  output logic             we_no_o,
  output logic             oe_no_o,
  output logic [ROW_W-1:0] addr_o,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o,
  input  logic [DW-1:0]    dq_i
);
  localparam int N_COL  = edo_max(edo_max(edo_cyc(T_CAS_NS, CLK_NS), edo_cyc(T_CAC_NS, CLK_NS)),
                                  edo_max(edo_cyc(T_AA_NS, CLK_NS) - 1, 1));
  localparam int N_ROW  = edo_max(edo_max(edo_cyc(T_RCD_NS, CLK_NS) - 1, 1),
                                  edo_cyc(T_RAC_NS, CLK_NS) - 1 - N_COL);
  localparam int N_CPR  = edo_max(edo_max(1, edo_cyc(T_CP_NS, CLK_NS) - 1),
                                  edo_cyc(T_HPC_NS, CLK_NS) - 1 - N_COL);
  localparam int N_RP   = edo_max(edo_cyc(T_RP_NS, CLK_NS), 1);
  localparam int N_RASL = edo_max(edo_cyc(T_RAS_NS, CLK_NS), edo_cyc(T_RC_NS, CLK_NS) - N_RP - 1);
  localparam int N_RASP = edo_cyc(T_RASP_NS, CLK_NS);
  localparam int N_GRD  = 2 * N_CPR + N_COL + 2;
  localparam int CW     = $clog2(N_RASP + 1);
  localparam logic [CW-1:0] L_ROW = CW'(N_ROW - 1);
  localparam logic [CW-1:0] L_COL = CW'(N_COL - 1);
  localparam logic [CW-1:0] L_CPR = CW'(N_CPR - 1);
  localparam logic [CW-1:0] L_RP  = CW'(N_RP - 1);

  edo_state_e       state_q, state_d;
  logic             wr_q;
  logic [COL_W-1:0] col_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic             done_q;
  logic [CW-1:0]    dwell;
  logic [ROW_W-1:0] open_row;
  logic             hit, rasl_ok, rasp_ok, acc, ras_low;

  edo_dwell #(.CW(CW)) i_dwell (
    .clk_i, .rst_ni,
    .restart_i (state_d != state_q),
    .cnt_o     (dwell)
  );

  edo_rowtrk #(
    .ROW_W(ROW_W), .CW(CW), .N_RASL(N_RASL), .N_RASP(N_RASP), .N_GUARD(N_GRD)
  ) i_rowtrk (
    .clk_i, .rst_ni,
    .open_i    (acc && state_q == ST_IDLE),
    .row_i     (req_row_i),
    .ras_low_i (ras_low),
    .cmp_row_i (req_row_i),
    .row_o     (open_row),
    .hit_o     (hit),
    .rasl_ok_o (rasl_ok),
    .rasp_ok_o (rasp_ok)
  );

  assign ras_low     = !(state_q == ST_IDLE || state_q == ST_RPRE);
  assign req_ready_o = (state_q == ST_IDLE) ||
                       (state_q == ST_CPRE && dwell >= L_CPR && hit && rasp_ok);
  assign acc         = req_valid_i && req_ready_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (acc) state_d = ST_ROW;
      ST_ROW:  if (dwell >= L_ROW) state_d = ST_CSET;
      ST_CSET: state_d = ST_COL;
      ST_COL:  if (dwell >= L_COL) state_d = ST_CPRE;
      ST_CPRE: if (dwell >= L_CPR) begin
                 if (acc)          state_d = ST_CSET;
                 else if (rasl_ok) state_d = ST_RPRE;
               end
      ST_RPRE: if (dwell >= L_RP) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      col_q   <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (acc) begin
        wr_q    <= req_write_i;
        col_q   <= req_col_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  // capture on the edge that ends the column strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_COL && dwell >= L_COL && !wr_q) begin
        rdata_q <= dq_i;
        done_q  <= 1'b1;
      end
    end
  end

  assign ras_no_o  = !ras_low;
  assign cas_no_o  = state_q != ST_COL;
  assign we_no_o   = !(wr_q && (state_q == ST_ROW || state_q == ST_CSET ||
                                state_q == ST_COL || state_q == ST_CPRE));
  assign oe_no_o   = !(!wr_q && state_q == ST_COL);
  assign addr_o    = (state_q == ST_ROW) ? open_row : ROW_W'(col_q);
  assign dq_o      = wdata_q;
  assign dq_oe_o   = wr_q && (state_q == ST_CSET || state_q == ST_COL);
  assign rd_data_o = rdata_q;
  assign rd_done_o = done_q;

  // R9
  accept_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !ras_no_o);
  // R6
  cas_in_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no_o |-> !ras_no_o);
  // R5
  drive_needs_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (!we_no_o && oe_no_o));
  // R4
  oe_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no_o |-> (we_no_o && !cas_no_o));
  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |=> !rd_done_o);
  // R3
  ras_min_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_no_o) |-> $past(rasl_ok));
endmodule

// File: tb/test_edo_seq.sv
module test_edo_seq;
  localparam int CLK = 20;
  localparam int RASP_NS = 1200;
  localparam int DW = 72;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0, req_ready, rd_done;
  logic [11:0]   req_row = '0, req_col = '0, addr;
  logic [DW-1:0] req_wdata = '0, rd_data, dq_o, dq_drv = '0;
  logic          ras_n, cas_n, we_n, oe_n, dq_oe;

  edo_seq #(.T_RASP_NS(RASP_NS)) i_edo_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_row_i(req_row), .req_col_i(req_col), .req_wdata_i(req_wdata),
    .rd_data_o(rd_data), .rd_done_o(rd_done),
    .ras_no_o(ras_n), .cas_no_o(cas_n), .we_no_o(we_n), .oe_no_o(oe_n),
    .addr_o(addr), .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_drv)
  );

  int tests = 0, fails = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int row, input int col);
    return {8'(row ^ col), 32'(row) ^ 32'h5a5a0000, 32'(col) ^ 32'h0000c3c3};
  endfunction

  // request side
  logic [DW-1:0] shadow [int];
  bit            q_wr  [$];
  int            q_row [$], q_col [$];
  logic [DW-1:0] q_dat [$], q_rd [$];

  task automatic issue(input bit wr, input int row, input int col, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = wr; req_row = 12'(row); req_col = 12'(col); req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    q_wr.push_back(wr); q_row.push_back(row); q_col.push_back(col); q_dat.push_back(d);
    if (wr) shadow[row*4096+col] = d;
    else q_rd.push_back(shadow.exists(row*4096+col) ? shadow[row*4096+col] : pat(row, col));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // DRAM model, evaluated away from the active edge
  logic [DW-1:0] mem [int];
  int  cyc_n = 0, t_rf = -1000, t_rr = -1000, t_cf = -1000, t_cr = -1000;
  int  n_act = 0, n_casf = 0;
  bit  pras = 1, pcas = 1, first = 1, cur_wr = 0;
  int  lrow = 0, lcol = 0;

  always @(negedge clk) if (rst_n) begin
    cyc_n++;
    if (pras && !ras_n) begin
      chk((cyc_n - t_rr) * CLK >= 40, "R3 precharge", 72'(cyc_n - t_rr), 72'd2);
      chk((cyc_n - t_rf) * CLK >= 104, "R3 cycle time", 72'(cyc_n - t_rf), 72'd6);
      t_rf = cyc_n; lrow = int'(addr); first = 1; n_act++;
    end
    if (!pras && ras_n) begin
      chk((cyc_n - t_rf) * CLK >= 60, "R3 ras low", 72'(cyc_n - t_rf), 72'd3);
      chk((cyc_n - t_rf) * CLK < RASP_NS, "R8 ras max", 72'(cyc_n - t_rf), 72'(RASP_NS / CLK));
      t_rr = cyc_n;
    end
    if (pcas && !cas_n) begin
      n_casf++; lcol = int'(addr);
      chk(!ras_n, "R6 cas inside ras", 72'(ras_n), 72'd0);
      chk((cyc_n - t_rf) * CLK >= 20, "R3 ras-to-cas", 72'(cyc_n - t_rf), 72'd1);
      if (!first) begin
        chk((cyc_n - t_cr) * CLK >= 10, "R6 cas precharge", 72'(cyc_n - t_cr), 72'd1);
        chk((cyc_n - t_cf) * CLK >= 25, "R6 page cycle", 72'(cyc_n - t_cf), 72'd2);
      end
      first = 0; t_cf = cyc_n;
      if (q_wr.size() == 0) chk(0, "R9 access without request", 72'd1, 72'd0);
      else begin
        automatic bit            a_wr  = q_wr.pop_front();
        automatic int            a_row = q_row.pop_front();
        automatic int            a_col = q_col.pop_front();
        automatic logic [DW-1:0] a_dat = q_dat.pop_front();
        chk(lrow == a_row, "R2 row latched", 72'(lrow), 72'(a_row));
        chk(lcol == a_col, "R7 R2 column latched", 72'(lcol), 72'(a_col));
        chk(we_n == !a_wr, "R4 R5 write select", 72'(we_n), 72'(!a_wr));
        cur_wr = a_wr;
        if (a_wr) begin
          chk(dq_oe && dq_o == a_dat, "R5 write data", dq_o, a_dat);
          mem[lrow*4096+lcol] = dq_o;
        end else
          dq_drv = mem.exists(lrow*4096+lcol) ? mem[lrow*4096+lcol] : pat(lrow, lcol);
      end
    end
    if (!cas_n && cur_wr)  chk(!we_n && oe_n, "R5 W held, OE off", {we_n, oe_n}, 72'd1);
    if (!cas_n && !cur_wr) chk(we_n && !oe_n, "R4 W high, OE on", {we_n, oe_n}, 72'd2);
    if (!pcas && cas_n) begin
      chk((cyc_n - t_cf) * CLK >= 15, "R4 cas low", 72'(cyc_n - t_cf), 72'd1);
      if (!cur_wr) chk((cyc_n - t_rf) * CLK >= 60, "R4 ras access", 72'(cyc_n - t_rf), 72'd3);
      t_cr = cyc_n; dq_drv = '0;
    end
    chk(rd_done == (!pcas && cas_n && !cur_wr), "R4 done pulse", 72'(rd_done), 72'(!pcas && cas_n && !cur_wr));
    if (rd_done) begin
      if (q_rd.size() == 0) chk(0, "R4 unexpected read", rd_data, '0);
      else begin
        automatic logic [DW-1:0] e = q_rd.pop_front();
        chk(rd_data == e, "R4 read data", rd_data, e);
      end
    end
    pras = ras_n; pcas = cas_n;
  end

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int a0, c0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk({ras_n, cas_n, we_n, oe_n, dq_oe, rd_done, req_ready} == 7'b1111001, "R1 reset state",
        72'({ras_n, cas_n, we_n, oe_n, dq_oe, rd_done, req_ready}), 72'b1111001);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n, dq_oe, rd_done, req_ready} == 7'b1111001, "R1 after reset",
        72'({ras_n, cas_n, we_n, oe_n, dq_oe, rd_done, req_ready}), 72'b1111001);

    // single write, then single read
    issue(1, 5, 7, 72'h12_3456789a_bcdef012);
    repeat (10) @(negedge clk);
    issue(0, 5, 7, '0);
    repeat (10) @(negedge clk);
    issue(0, 100, 200, '0);             // never written
    repeat (10) @(negedge clk);

    // page burst: one activation for eight accesses to one row
    a0 = n_act; c0 = n_casf;
    for (int i = 0; i < 4; i++) issue(1, 9, i, pat(i + 40, 9));
    for (int i = 0; i < 4; i++) issue(0, 9, i, '0);
    repeat (10) @(negedge clk);
    chk(n_act - a0 == 1, "R6 single activation in page", 72'(n_act - a0), 72'd1);
    chk(n_casf - c0 == 8, "R6 column accesses in page", 72'(n_casf - c0), 72'd8);

    // row miss forces a reopen
    a0 = n_act;
    issue(0, 9, 0, '0);
    issue(0, 10, 1, '0);
    issue(0, 9, 3, '0);
    repeat (10) @(negedge clk);
    chk(n_act - a0 == 3, "R7 activation per row change", 72'(n_act - a0), 72'd3);

    // long burst runs into the row-low limit
    a0 = n_act;
    for (int i = 0; i < 40; i++) issue(i % 3 == 0, 3, i, pat(i, 77));
    repeat (10) @(negedge clk);
    chk(n_act - a0 >= 2, "R8 row reopened at limit", 72'(n_act - a0), 72'd2);

    // address corners
    issue(1, 4095, 4095, '1);
    issue(1, 0, 0, 72'h0f_00ff00ff_00ff00ff);
    issue(0, 4095, 4095, '0);
    issue(0, 0, 0, '0);
    repeat (15) @(negedge clk);

    // R9: row closed with nothing waiting
    chk(ras_n && cas_n && req_ready, "R9 idle closes row", 72'({ras_n, cas_n, req_ready}), 72'd7);
    chk(q_rd.size() == 0 && q_wr.size() == 0, "R9 all requests served", 72'(q_rd.size() + q_wr.size()), 72'd0);
    finish_run();
  end
endmodule